// File: doc/BRIEF.md
# Supply Switchover Time Stamp Unit

This block records the calendar time at which the device's power source changes. A digital level tells it whether the part currently runs from the main supply or from the backup battery. The block compares that level with its value one cycle earlier. When the level changes, it copies the live BCD time (seconds, minutes, hours, date and month) into one of two read-only banks.

The bank for main-to-battery events is armed once and keeps the first event only. The bank for battery-to-main events is overwritten on every such event, so it always shows the latest return to main power. A single-cycle clear strobe wipes both banks to all zeros and re-arms the first-event bank. Because live time fields never read as zero in date or month, an all-zero bank means nothing has been captured since the last clear or reset.

Top module: `pwr_stamp_capture`

## Requirements
- R1: While `rst` is high, and on the first rising clock edge after it falls when no source change occurs, both banks read as all zeros in every field.
- R2: On a capture, a bank holds the seconds, minutes, hours, date and month inputs exactly as they stood on the clock edge where the source change was seen. The bank shows them from the edge that follows the change on `on_batt`.
- R3: A change of `on_batt` from 0 (main) to 1 (battery) loads the main-to-battery bank only if that bank has not been loaded since the last clear or reset. Later 0-to-1 changes leave it unchanged.
- R4: Every change of `on_batt` from 1 to 0 loads the battery-to-main bank with the current time and replaces any earlier contents.
- R5: A cycle with `clr_stamp` high and no source change sets both banks to all zeros and re-arms the main-to-battery bank for its next event.
- R6: When `clr_stamp` is high in the same cycle as a source change, the bank that owns that change takes the new time, including the main-to-battery bank when it is already loaded. The other bank is cleared.
- R7: The level on `on_batt` while reset is held is not an event. If `on_batt` is still at that level after reset, neither bank captures.
- R8: Changes of the time inputs while `on_batt` is steady and `clr_stamp` is low leave both banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| on_batt | input | 1 | Supply source level: 1 = battery, 0 = main |
| clr_stamp | input | 1 | One-cycle strobe that clears both banks |
| now_sec | input | 8 | Live seconds, BCD |
| now_min | input | 8 | Live minutes, BCD |
| now_hour | input | 8 | Live hours, BCD |
| now_date | input | 8 | Live day of month, BCD |
| now_mon | input | 8 | Live month, BCD |
| m2b_sec | output | 8 | Main-to-battery bank: seconds |
| m2b_min | output | 8 | Main-to-battery bank: minutes |
| m2b_hour | output | 8 | Main-to-battery bank: hours |
| m2b_date | output | 8 | Main-to-battery bank: date |
| m2b_mon | output | 8 | Main-to-battery bank: month |
| b2m_sec | output | 8 | Battery-to-main bank: seconds |
| b2m_min | output | 8 | Battery-to-main bank: minutes |
| b2m_hour | output | 8 | Battery-to-main bank: hours |
| b2m_date | output | 8 | Battery-to-main bank: date |
| b2m_mon | output | 8 | Battery-to-main bank: month |

## Verification
The source level is driven through several patterns:
- A battery level held across reset separates a true change from a power-up level.
- Repeated main/battery toggles with a distinct time on each edge show whether the first-event bank holds and the last-event bank overwrites.
- Steady stretches with a moving time catch spurious loads.
- A clear with no change, followed by a fresh battery event, shows whether the bank is re-armed.
- A clear on the same edge as each kind of change shows which action wins in each bank.
- Every field of each time value differs, so a swapped or dropped field shows up.

// File: rtl/pwr_stamp_pkg.sv
package pwr_stamp_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 5;
  localparam int STAMP_W    = FIELD_W * NUM_FIELDS;

  typedef struct packed {
    logic [FIELD_W-1:0] mon;
    logic [FIELD_W-1:0] date;
    logic [FIELD_W-1:0] hour;
    logic [FIELD_W-1:0] min;
    logic [FIELD_W-1:0] sec;
  } stamp_t;

  localparam stamp_t STAMP_ZERO = '0;
endpackage

// File: rtl/pwr_src_edge.sv
module pwr_src_edge (
  input  logic clk,
  input  logic level,
  output logic went_high,
  output logic went_low
);
  logic level_q;

  // Tracks the level during reset as well, so a level held through
  // reset never looks like a change afterwards.
  always_ff @(posedge clk) begin
    level_q <= level;
  end

  always_comb begin
    went_high = level & ~level_q;
    went_low  = ~level & level_q;
  end
endmodule

// File: rtl/pwr_stamp_bank.sv
module pwr_stamp_bank
  import pwr_stamp_pkg::*;
#(
  parameter bit KEEP_FIRST = 1'b1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   capture,
  input  logic   clear,
  input  stamp_t now,
  output stamp_t bank
);
  stamp_t bank_q;

  generate
    if (KEEP_FIRST) begin : g_first
      logic armed_n_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          bank_q    <= STAMP_ZERO;
          armed_n_q <= 1'b0;
        end else if (capture && (!armed_n_q || clear)) begin
          bank_q    <= now;
          armed_n_q <= 1'b1;
        end else if (clear) begin
          bank_q    <= STAMP_ZERO;
          armed_n_q <= 1'b0;
        end
      end
    end else begin : g_last
      always_ff @(posedge clk) begin
        if (rst) begin
          bank_q <= STAMP_ZERO;
        end else if (capture) begin
          bank_q <= now;
        end else if (clear) begin
          bank_q <= STAMP_ZERO;
        end
      end
    end
  endgenerate

  assign bank = bank_q;
endmodule

// File: rtl/pwr_stamp_capture.sv
module pwr_stamp_capture
  import pwr_stamp_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               on_batt,
  input  logic               clr_stamp,
  input  logic [FIELD_W-1:0] now_sec,
  input  logic [FIELD_W-1:0] now_min,
  input  logic [FIELD_W-1:0] now_hour,
  input  logic [FIELD_W-1:0] now_date,
  input  logic [FIELD_W-1:0] now_mon,
  output logic [FIELD_W-1:0] m2b_sec,
  output logic [FIELD_W-1:0] m2b_min,
  output logic [FIELD_W-1:0] m2b_hour,
  output logic [FIELD_W-1:0] m2b_date,
  output logic [FIELD_W-1:0] m2b_mon,
  output logic [FIELD_W-1:0] b2m_sec,
  output logic [FIELD_W-1:0] b2m_min,
  output logic [FIELD_W-1:0] b2m_hour,
  output logic [FIELD_W-1:0] b2m_date,
  output logic [FIELD_W-1:0] b2m_mon
);
  stamp_t now_s;
  stamp_t m2b_s;
  stamp_t b2m_s;
  logic   to_batt;
  logic   to_main;

  assign now_s = '{mon: now_mon, date: now_date, hour: now_hour,
                   min: now_min, sec: now_sec};

  pwr_src_edge u_edge (
    .clk       (clk),
    .level     (on_batt),
    .went_high (to_batt),
    .went_low  (to_main)
  );

  pwr_stamp_bank #(.KEEP_FIRST(1'b1)) u_m2b (
    .clk     (clk),
    .rst     (rst),
    .capture (to_batt),
    .clear   (clr_stamp),
    .now     (now_s),
    .bank    (m2b_s)
  );

  pwr_stamp_bank #(.KEEP_FIRST(1'b0)) u_b2m (
    .clk     (clk),
    .rst     (rst),
    .capture (to_main),
    .clear   (clr_stamp),
    .now     (now_s),
    .bank    (b2m_s)
  );

  assign m2b_sec  = m2b_s.sec;
  assign m2b_min  = m2b_s.min;
  assign m2b_hour = m2b_s.hour;
  assign m2b_date = m2b_s.date;
  assign m2b_mon  = m2b_s.mon;
  assign b2m_sec  = b2m_s.sec;
  assign b2m_min  = b2m_s.min;
  assign b2m_hour = b2m_s.hour;
  assign b2m_date = b2m_s.date;
  assign b2m_mon  = b2m_s.mon;
endmodule

// File: rtl/pwr_stamp_checker.sv
module pwr_stamp_checker
  import pwr_stamp_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               on_batt,
  input logic               clr_stamp,
  input logic [STAMP_W-1:0] now_v,
  input logic [STAMP_W-1:0] m2b_v,
  input logic [STAMP_W-1:0] b2m_v
);
  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (m2b_v == '0 && b2m_v == '0)); // R1

  AST_MAIN_LOAD: assert property (@(posedge clk) disable iff (rst)
    $fell(on_batt) |=> (b2m_v == $past(now_v))); // R4

  AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (m2b_v != '0 && !clr_stamp) |=> $stable(m2b_v)); // R3

  AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (rst)
    (clr_stamp && !$rose(on_batt) && !$fell(on_batt))
      |=> (m2b_v == '0 && b2m_v == '0)); // R5

  AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (rst)
    (clr_stamp && $rose(on_batt)) |=> (m2b_v == $past(now_v))); // R6

  AST_STEADY_KEEP: assert property (@(posedge clk) disable iff (rst)
    ($stable(on_batt) && !clr_stamp) |=> ($stable(m2b_v) && $stable(b2m_v))); // R8
endmodule

bind pwr_stamp_capture pwr_stamp_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .on_batt   (on_batt),
  .clr_stamp (clr_stamp),
  .now_v     (now_s),
  .m2b_v     (m2b_s),
  .b2m_v     (b2m_s)
);

// File: tb/pwr_stamp_capture_tb.sv
`timescale 1ns/1ps
module pwr_stamp_capture_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        on_batt = 1'b1;
  logic        clr_stamp = 1'b0;
  logic [39:0] now_v = '0;
  logic [7:0]  m2b_sec, m2b_min, m2b_hour, m2b_date, m2b_mon;
  logic [7:0]  b2m_sec, b2m_min, b2m_hour, b2m_date, b2m_mon;

  typedef struct {
    logic [39:0] m2b;
    logic [39:0] b2m;
    string       req;
  } item_t;

  item_t       exp_q[$];
  int          n_checks = 0;
  int          n_fail = 0;
  logic [39:0] mdl_m2b = '0;
  logic [39:0] mdl_b2m = '0;
  bit          mdl_full = 0;
  logic        mdl_prev = 1'b1;
  bit          done = 0;

  always #2.5 clk = ~clk;

  pwr_stamp_capture u_dut (
    .clk(clk), .rst(rst), .on_batt(on_batt), .clr_stamp(clr_stamp),
    .now_sec(now_v[7:0]), .now_min(now_v[15:8]), .now_hour(now_v[23:16]),
    .now_date(now_v[31:24]), .now_mon(now_v[39:32]),
    .m2b_sec(m2b_sec), .m2b_min(m2b_min), .m2b_hour(m2b_hour),
    .m2b_date(m2b_date), .m2b_mon(m2b_mon),
    .b2m_sec(b2m_sec), .b2m_min(b2m_min), .b2m_hour(b2m_hour),
    .b2m_date(b2m_date), .b2m_mon(b2m_mon)
  );

  // Driver: apply one cycle of stimulus and queue the expected banks.
  task automatic drive(input logic batt, input logic clr,
                       input logic [39:0] t, input string req);
    item_t it;
    bit up, dn;
    @(negedge clk);
    on_batt = batt; clr_stamp = clr; now_v = t;
    up = batt && !mdl_prev;
    dn = !batt && mdl_prev;
    if (up && (!mdl_full || clr)) begin mdl_m2b = t; mdl_full = 1; end
    else if (clr) begin mdl_m2b = '0; mdl_full = 0; end
    if (dn) mdl_b2m = t;
    else if (clr) mdl_b2m = '0;
    mdl_prev = batt;
    it.m2b = mdl_m2b; it.b2m = mdl_b2m; it.req = req;
    exp_q.push_back(it);
  endtask

  function automatic logic [39:0] tm(input int k);
    // month, date, hour, min, sec as distinct BCD values
    return {8'h01 + 8'(k % 9), 8'h10 + 8'(k % 9), 8'h05 + 8'(k % 4),
            8'h20 + 8'(k % 9), 8'h30 + 8'(k % 9)};
  endfunction

  // Monitor: compare one item after each clock edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      item_t it;
      logic [39:0] am, ab;
      it = exp_q.pop_front();
      am = {m2b_mon, m2b_date, m2b_hour, m2b_min, m2b_sec};
      ab = {b2m_mon, b2m_date, b2m_hour, b2m_min, b2m_sec};
      n_checks++;
      if (am !== it.m2b || ab !== it.b2m) begin
        n_fail++;
        $display("FAIL %s: m2b=%h b2m=%h expected m2b=%h b2m=%h",
                 it.req, am, ab, it.m2b, it.b2m);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: banks zero while reset is high
    n_checks++;
    if ({m2b_mon, m2b_date, m2b_hour, m2b_min, m2b_sec,
         b2m_mon, b2m_date, b2m_hour, b2m_min, b2m_sec} !== '0) begin
      n_fail++;
      $display("FAIL R1: banks non-zero in reset, expected 0");
    end
    rst = 1'b0;
    drive(1'b1, 1'b0, tm(1), "R1 R7 battery level held through reset");
    drive(1'b1, 1'b0, tm(2), "R7 no capture after reset");
    drive(1'b0, 1'b0, tm(3), "R4 R2 first return to main");
    drive(1'b0, 1'b0, tm(4), "R8 steady main");
    drive(1'b1, 1'b0, tm(5), "R3 R2 first battery event");
    drive(1'b1, 1'b0, tm(6), "R8 steady battery");
    drive(1'b0, 1'b0, tm(7), "R4 overwrite");
    drive(1'b1, 1'b0, tm(8), "R3 later battery ignored");
    drive(1'b0, 1'b0, tm(9), "R4 latest kept");
    drive(1'b0, 1'b1, tm(10), "R5 clear both");
    drive(1'b0, 1'b0, tm(11), "R8 after clear");
    drive(1'b1, 1'b0, tm(12), "R5 re-armed capture");
    drive(1'b0, 1'b1, tm(13), "R6 clear with return to main");
    drive(1'b1, 1'b1, tm(14), "R6 clear with battery event");
    drive(1'b0, 1'b0, tm(15), "R4 main after R6");
    drive(1'b1, 1'b1, tm(16), "R6 capture wins over clear when loaded");
    for (int k = 17; k < 40; k++)
      drive(((k / 3) % 2) == 1, (k % 11) == 0, tm(k), "R3 R4 R8 toggle run");
    drive(1'b1, 1'b0, tm(41), "R8 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule